// File: doc/BRIEF.md
# Register Valid-Bit Scoreboard Interlock

This block detects dependences for an in-order five-stage pipeline (fetch, decode, execute, memory, writeback). It holds one valid bit for each architectural register and keeps no other tracking state. A cleared bit means that some instruction past decode will still write that register. Each cycle, decode presents the instruction it holds: its source register numbers, its destination register number, a use flag for each of these fields, and an issue request. Writeback presents a retire strobe with the register number it is writing.

The block compares the used fields against the valid bits. It raises a stall to decode when any checked register is pending. The destination is checked along with the sources, so a single bit per register holds back true dependences and also write-after-write and write-after-read orderings. When an instruction issues, the valid bit of its destination is cleared. When writeback completes, the bit is set again. A retire in the current cycle counts as valid for the check made in that same cycle, which avoids a one-cycle bubble.

The default configuration has eight registers with three-bit register numbers and two source fields per instruction.

Top module: `reg_hazard_scoreboard`

## Requirements
- R1: While reset (rst_n low) is held and after it is released, all valid bits are set, so no register is pending.
- R2: dec_stall is high only when dec_issue_req is high. With no request, dec_stall stays low.
- R3: An instruction issues when dec_issue_req is high and dec_stall is low. If dec_dst_use is also high, the valid bit of dec_dst_idx is clear from the next cycle on.
- R4: A cycle with wb_retire high sets the valid bit of wb_dst_idx from the next cycle on, unless R10 applies.
- R5: While an instruction is stalled, it clears no valid bit. Only a retire changes the bits in that cycle.
- R6: When a used source field (dec_src_use[i] high, with register number dec_src_idx[i*3 +: 3]) names a pending register, dec_stall is high.
- R7: When the used destination field names a pending register, dec_stall is high. This holds back write-after-write and write-after-read orderings.
- R8: A field whose use flag is low is left out of the check, even when it names a pending register.
- R9: A register being retired in the current cycle counts as valid for that cycle's check.
- R10: If an issuing instruction writes the same register that retires in the same cycle, the bit ends up clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| dec_issue_req | input | 1 | Decode holds an instruction that asks to issue |
| dec_src_idx | input | 6 | Source register numbers; field i is bits [i*3 +: 3] |
| dec_src_use | input | 2 | Use flag for each source field |
| dec_dst_idx | input | 3 | Destination register number |
| dec_dst_use | input | 1 | The instruction writes dec_dst_idx |
| wb_retire | input | 1 | Writeback completes a register write this cycle |
| wb_dst_idx | input | 3 | Register written by writeback |
| dec_stall | output | 1 | Hold decode; the instruction does not issue |

## Verification
The bench aims at the timing corners of a single bit per register. A retire that arrives while a reader is waiting must release it in that same cycle; a design without the bypass would stall one cycle too long. An issue and a retire on the same register in the same cycle must leave the register pending; a design that lets the set win would let a later reader go through too early. A stall that lasts several cycles must not clear the destination bit of the held instruction, and fields whose use flag is low must not be checked; a design that gets either wrong would deadlock or stall for no reason, which the bench sees through the stall output.

// File: rtl/sb_pkg.sv
// Package: shared constants for the register scoreboard.
// Assumes: register numbers are binary and the register count is a power of two.
package sb_pkg;
    localparam int SB_NUM_REGS = 8;  // architectural registers tracked
    localparam int SB_NUM_SRC  = 2;  // source fields per instruction

    // Width of a register number for a given register count.
    function automatic int sb_idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/sb_onehot.sv
// Module: sb_onehot
// Turns an enabled register number into a one-hot mask over all registers.
// Assumes: NUM_REGS equals 2**IDX_W so that every index value is in range.
module sb_onehot #(
    parameter int NUM_REGS = 8,
    parameter int IDX_W    = 3
) (
    input  logic [IDX_W-1:0]    idx,
    input  logic                en,
    output logic [NUM_REGS-1:0] mask
);
    // One comparator per register.
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_bit
        assign mask[r] = en && (idx == IDX_W'(r));
    end
endmodule

// File: rtl/sb_valid_array.sv
// Module: sb_valid_array
// Holds the valid bit of each register. A clear request takes priority over a
// set request on the same bit, because the new writer is still in flight.
// Assumes: synchronous active-low reset, which sets every bit.
module sb_valid_array #(
    parameter int NUM_REGS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_REGS-1:0] set_mask,
    input  logic [NUM_REGS-1:0] clr_mask,
    output logic [NUM_REGS-1:0] valid_q
);
    // Update all bits: reset sets them, clear beats set.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= '1;
        else        valid_q <= (valid_q | set_mask) & ~clr_mask;
    end
endmodule

// File: rtl/sb_hazard_check.sv
// Module: sb_hazard_check
// Looks up the effective valid bit of each used field of the decode
// instruction and raises a stall when any of them is pending.
// Assumes: valid_eff already includes the same-cycle retire bypass.
module sb_hazard_check #(
    parameter int NUM_REGS = 8,
    parameter int IDX_W    = 3,
    parameter int NUM_SRC  = 2
) (
    input  logic [NUM_REGS-1:0]      valid_eff,
    input  logic                     req,
    input  logic [NUM_SRC*IDX_W-1:0] src_idx,
    input  logic [NUM_SRC-1:0]       src_use,
    input  logic [IDX_W-1:0]         dst_idx,
    input  logic                     dst_use,
    output logic                     stall
);
    logic [NUM_SRC-1:0] src_hit;
    logic               dst_hit;

    // One pending test per source field.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign src_hit[i] = src_use[i] && !valid_eff[src_idx[i*IDX_W +: IDX_W]];
    end

    // Destination test, which covers write-after-write and write-after-read.
    assign dst_hit = dst_use && !valid_eff[dst_idx];

    // Stall only for an instruction that asks to issue.
    always_comb begin
        stall = req && ((|src_hit) || dst_hit);
    end
endmodule

// File: rtl/reg_hazard_scoreboard.sv
// Module: reg_hazard_scoreboard (top)
// Dependence interlock built on one valid bit per register. An issue clears
// the destination bit and a writeback retire sets it again. Decode stalls
// while any used field names a pending register.
// Assumes: in-order issue, one issue and one retire per cycle at most.
module reg_hazard_scoreboard #(
    parameter int NUM_REGS = sb_pkg::SB_NUM_REGS,
    parameter int NUM_SRC  = sb_pkg::SB_NUM_SRC,
    localparam int IDX_W   = sb_pkg::sb_idx_width(NUM_REGS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     dec_issue_req,
    input  logic [NUM_SRC*IDX_W-1:0] dec_src_idx,
    input  logic [NUM_SRC-1:0]       dec_src_use,
    input  logic [IDX_W-1:0]         dec_dst_idx,
    input  logic                     dec_dst_use,
    input  logic                     wb_retire,
    input  logic [IDX_W-1:0]         wb_dst_idx,
    output logic                     dec_stall
);
    logic [NUM_REGS-1:0] valid_q;
    logic [NUM_REGS-1:0] set_mask;
    logic [NUM_REGS-1:0] clr_mask;
    logic [NUM_REGS-1:0] valid_eff;
    logic                issue;

    // Retire mask: the register that writeback completes this cycle.
    sb_onehot #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) i_set_dec (
        .idx (wb_dst_idx),
        .en  (wb_retire),
        .mask(set_mask)
    );

    // Issue mask: the destination of an instruction that actually leaves decode.
    sb_onehot #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) i_clr_dec (
        .idx (dec_dst_idx),
        .en  (issue && dec_dst_use),
        .mask(clr_mask)
    );

    // Valid bits, with the same-cycle retire folded in for the check.
    sb_valid_array #(.NUM_REGS(NUM_REGS)) i_valid (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_mask(set_mask),
        .clr_mask(clr_mask),
        .valid_q (valid_q)
    );

    assign valid_eff = valid_q | set_mask;

    // Compare the used fields against the effective bits.
    sb_hazard_check #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .NUM_SRC(NUM_SRC)) i_check (
        .valid_eff(valid_eff),
        .req      (dec_issue_req),
        .src_idx  (dec_src_idx),
        .src_use  (dec_src_use),
        .dst_idx  (dec_dst_idx),
        .dst_use  (dec_dst_use),
        .stall    (dec_stall)
    );

    assign issue = dec_issue_req && !dec_stall;
endmodule

// File: rtl/sb_checker.sv
// Module: sb_checker
// Property checks on the scoreboard, attached to the top through bind.
// Assumes: it sees the top's ports and its registered valid vector.
module sb_checker #(
    parameter int NUM_REGS = 8,
    parameter int NUM_SRC  = 2,
    parameter int IDX_W    = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     dec_issue_req,
    input logic [NUM_SRC*IDX_W-1:0] dec_src_idx,
    input logic [NUM_SRC-1:0]       dec_src_use,
    input logic [IDX_W-1:0]         dec_dst_idx,
    input logic                     dec_dst_use,
    input logic                     wb_retire,
    input logic [IDX_W-1:0]         wb_dst_idx,
    input logic                     dec_stall,
    input logic [NUM_REGS-1:0]      valid_q
);
    logic issue_w;
    assign issue_w = dec_issue_req && !dec_stall && dec_dst_use;

    assert_reset_all_valid_R1: assert property (@(posedge clk)
        !rst_n |=> (valid_q == '1));

    assert_stall_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_stall |-> dec_issue_req);

    assert_issue_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        issue_w |=> !valid_q[$past(dec_dst_idx)]);

    assert_retire_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_retire && !(issue_w && dec_dst_idx == wb_dst_idx)) |=> valid_q[$past(wb_dst_idx)]);

    assert_stall_keeps_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_stall && !wb_retire) |=> $stable(valid_q));

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src_chk
        assert_src_pending_stalls_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_issue_req && dec_src_use[i] && !valid_q[dec_src_idx[i*IDX_W +: IDX_W]]
             && !(wb_retire && wb_dst_idx == dec_src_idx[i*IDX_W +: IDX_W])) |-> dec_stall);
    end

    assert_dst_pending_stalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_issue_req && dec_dst_use && !valid_q[dec_dst_idx]
         && !(wb_retire && wb_dst_idx == dec_dst_idx)) |-> dec_stall);

    assert_clear_beats_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_w && wb_retire && dec_dst_idx == wb_dst_idx) |=> !valid_q[$past(wb_dst_idx)]);
endmodule

bind reg_hazard_scoreboard sb_checker #(
    .NUM_REGS(NUM_REGS), .NUM_SRC(NUM_SRC), .IDX_W(IDX_W)
) i_sb_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .dec_issue_req(dec_issue_req),
    .dec_src_idx  (dec_src_idx),
    .dec_src_use  (dec_src_use),
    .dec_dst_idx  (dec_dst_idx),
    .dec_dst_use  (dec_dst_use),
    .wb_retire    (wb_retire),
    .wb_dst_idx   (wb_dst_idx),
    .dec_stall    (dec_stall),
    .valid_q      (valid_q)
);

// File: tb/test_reg_hazard_scoreboard.sv
// Directed bench for reg_hazard_scoreboard. Inputs change on the falling
// edge and the stall output is sampled 1 ns later, before the next rising edge.
module test_reg_hazard_scoreboard;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       dec_issue_req;
    logic [5:0] dec_src_idx;
    logic [1:0] dec_src_use;
    logic [2:0] dec_dst_idx;
    logic       dec_dst_use;
    logic       wb_retire;
    logic [2:0] wb_dst_idx;
    logic       dec_stall;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;  // 200 MHz

    reg_hazard_scoreboard i_reg_hazard_scoreboard (
        .clk(clk), .rst_n(rst_n), .dec_issue_req(dec_issue_req),
        .dec_src_idx(dec_src_idx), .dec_src_use(dec_src_use),
        .dec_dst_idx(dec_dst_idx), .dec_dst_use(dec_dst_use),
        .wb_retire(wb_retire), .wb_dst_idx(wb_dst_idx), .dec_stall(dec_stall)
    );

    task automatic chk(input logic act, input logic exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: dec_stall=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Present an instruction on the falling edge; the stall settles 1 ns later.
    task automatic put(input logic req, input logic [2:0] s0, input logic u0,
                       input logic [2:0] s1, input logic u1,
                       input logic [2:0] d, input logic du);
        @(negedge clk);
        dec_issue_req = req;
        dec_src_idx   = {s1, s0};
        dec_src_use   = {u1, u0};
        dec_dst_idx   = d;
        dec_dst_use   = du;
        wb_retire     = 1'b0;
        #1;
    endtask

    task automatic retire_now(input logic [2:0] r);
        wb_retire  = 1'b1;
        wb_dst_idx = r;
        #1;
    endtask

    task automatic idle();
        put(1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0);
    endtask

    // Read one valid bit through the stall: a reader of r stalls only if r is pending.
    task automatic probe(input logic [2:0] r, input logic pending, input string req);
        put(1'b1, r, 1'b1, 3'd0, 1'b0, 3'd0, 1'b0);
        chk(dec_stall, pending, req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        dec_issue_req = 1'b0; dec_src_idx = '0; dec_src_use = '0;
        dec_dst_idx = '0; dec_dst_use = 1'b0; wb_retire = 1'b0; wb_dst_idx = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1: every register is valid after reset.
    task automatic t_reset();
        do_reset();
        for (int r = 0; r < 8; r++) probe(3'(r), 1'b0, "R1");
    endtask

    // R3, R6, R9, R4: writer issues, reader waits, retire releases it in the same cycle.
    task automatic t_raw();
        do_reset();
        put(1'b1, 3'd1, 1'b1, 3'd2, 1'b1, 3'd3, 1'b1);
        chk(dec_stall, 1'b0, "R3");
        put(1'b1, 3'd0, 1'b0, 3'd3, 1'b1, 3'd4, 1'b1);
        chk(dec_stall, 1'b1, "R6");
        put(1'b1, 3'd0, 1'b0, 3'd3, 1'b1, 3'd4, 1'b1);
        chk(dec_stall, 1'b1, "R6");
        retire_now(3'd3);
        chk(dec_stall, 1'b0, "R9");
        idle();
        probe(3'd3, 1'b0, "R4");
        probe(3'd4, 1'b1, "R3");
    endtask

    // R7: a second writer of a pending register is held back.
    task automatic t_waw();
        do_reset();
        put(1'b1, 3'd0, 1'b0, 3'd0, 1'b0, 3'd5, 1'b1);
        chk(dec_stall, 1'b0, "R3");
        put(1'b1, 3'd0, 1'b0, 3'd0, 1'b0, 3'd5, 1'b1);
        chk(dec_stall, 1'b1, "R7");
    endtask

    // R8: unused fields naming a pending register do not stall.
    task automatic t_unused();
        do_reset();
        put(1'b1, 3'd0, 1'b0, 3'd0, 1'b0, 3'd2, 1'b1);
        put(1'b1, 3'd2, 1'b0, 3'd2, 1'b0, 3'd2, 1'b0);
        chk(dec_stall, 1'b0, "R8");
        put(1'b1, 3'd6, 1'b1, 3'd2, 1'b1, 3'd7, 1'b0);
        chk(dec_stall, 1'b1, "R8");
    endtask

    // R5: a held instruction does not clear its destination bit.
    task automatic t_stall_no_clear();
        do_reset();
        put(1'b1, 3'd0, 1'b0, 3'd0, 1'b0, 3'd1, 1'b1);
        for (int k = 0; k < 3; k++) begin
            put(1'b1, 3'd1, 1'b1, 3'd0, 1'b0, 3'd4, 1'b1);
            chk(dec_stall, 1'b1, "R5");
        end
        probe(3'd4, 1'b0, "R5");
    endtask

    // R10: issue and retire of the same register in one cycle leaves it pending.
    task automatic t_same_cycle();
        do_reset();
        put(1'b1, 3'd0, 1'b0, 3'd0, 1'b0, 3'd6, 1'b1);
        put(1'b1, 3'd0, 1'b0, 3'd0, 1'b0, 3'd6, 1'b1);
        retire_now(3'd6);
        chk(dec_stall, 1'b0, "R9");
        probe(3'd6, 1'b1, "R10");
        put(1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0);
        retire_now(3'd6);
        probe(3'd6, 1'b0, "R4");
    endtask

    // R2: no request, no stall, even with every field pointing at a pending register.
    task automatic t_no_req();
        do_reset();
        put(1'b1, 3'd0, 1'b0, 3'd0, 1'b0, 3'd7, 1'b1);
        put(1'b0, 3'd7, 1'b1, 3'd7, 1'b1, 3'd7, 1'b1);
        chk(dec_stall, 1'b0, "R2");
        probe(3'd7, 1'b1, "R2");
    endtask

    initial begin
        rst_n = 1'b0;
        dec_issue_req = 1'b0; dec_src_idx = '0; dec_src_use = '0;
        dec_dst_idx = '0; dec_dst_use = 1'b0; wb_retire = 1'b0; wb_dst_idx = '0;
        t_reset();
        t_raw();
        t_waw();
        t_unused();
        t_stall_no_clear();
        t_same_cycle();
        t_no_req();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule